// File: doc/BRIEF.md
# Up/Down Interval Timer with Module Standby

This block is an interval timer with a single counter, eight bits wide by default. It advances by one step on each enable strobe from a selectable count source. Seven prescaler taps and one external input are offered as single-cycle strobes on the system clock. A 3-bit field in the control byte picks the source. The count direction is either fixed by software (up or down) or taken from a hardware pin that is sampled on every strobe.

When the counter passes its end value (above the maximum going up, or below zero going down), it wraps around and keeps going in the same direction. The wrap sets a sticky request flag. The interrupt line follows the flag, gated by an enable bit. A run bit, which is set after reset, puts the block into module standby when written to 0. In standby the counter and the flag keep their values, strobes and flag clears are ignored, and the control byte and enable bit still accept writes.

After reset the block counts up from zero on prescaler tap 0, with no setup needed. Register writes come in as plain write-enable and data pins, and register contents are visible on output ports.

Top module: `updn_interval_timer`

## Requirements
- R1: Control bit 7 at 0 gives interval counting. At 1 the counter holds its value, whatever the strobes do.
- R2: After a synchronous reset: count 0x00, control byte 0x18, run bit 1, request flag 0, interrupt enable 0. Control bits 4 and 3 always read as 1, whatever is written to them.
- R3: Control bits 2..0 select the count source: a value k from 0 to 6 picks tap_stb[k], and 7 picks ext_stb. Each cycle with the selected strobe high moves the count by exactly one step. Strobes on other sources are ignored. The new count is visible after the next rising clock edge.
- R4: Control bits 6..5 set the direction: 00 counts up, 01 counts down, and 10 or 11 follow hw_down (1 = down, 0 = up) as sampled in the strobe cycle.
- R5: An up step from the all-ones value gives 0x00. A down step from 0x00 gives the all-ones value. Either wrap sets the request flag in the same edge, and counting continues in the same direction.
- R6: The request flag stays at 1 until a flag_clr pulse. If a clear and a wrap fall in the same cycle, the flag stays at 1.
- R7: irq_o is high exactly while the request flag and the interrupt enable bit are both 1.
- R8: While the run bit is 0, count and flag hold, strobes and flag_clr have no effect, and writes to the control byte and enable bit still take effect. Writing the run bit back to 1 resumes counting from the held value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_we | input | 1 | Write strobe for the control byte |
| mode_wd | input | 8 | Control byte write data |
| mode_o | output | 8 | Control byte readback |
| stby_we | input | 1 | Write strobe for the run bit |
| stby_wd | input | 1 | Run bit write data (0 = standby) |
| run_o | output | 1 | Run bit readback |
| ien_we | input | 1 | Write strobe for interrupt enable |
| ien_wd | input | 1 | Interrupt enable write data |
| ien_o | output | 1 | Interrupt enable readback |
| flag_clr | input | 1 | Request flag clear pulse |
| flag_o | output | 1 | Sticky wrap request flag |
| irq_o | output | 1 | Interrupt request |
| tap_stb | input | 7 | Prescaler tap strobes, one cycle each |
| ext_stb | input | 1 | External count strobe, one cycle |
| hw_down | input | 1 | Hardware direction pin (1 = down) |
| count_o | output | 8 | Counter value |

## Verification
The properties assume that every count source arrives as a strobe already synchronised to the system clock. They also assume that the hardware direction pin is stable around the edge where a strobe is taken, so a wrap is always exactly one step from the previous value. The bench drives every strobe, direction level and register write on the falling edge and holds it for one full cycle, which keeps the stimulus within those assumptions. Several tap strobes are sometimes raised together, but only one edge's worth of movement is ever expected.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int CLK_SEL_W = 3;
    localparam int N_SRC     = 2 ** CLK_SEL_W;
    localparam int N_TAPS    = N_SRC - 1;
    localparam int MODE_W    = 8;
    localparam logic [MODE_W-1:0] MODE_RST = 8'h18;

    typedef enum logic [1:0] {
        DIR_SW_UP = 2'b00,
        DIR_SW_DN = 2'b01,
        DIR_HW_A  = 2'b10,
        DIR_HW_B  = 2'b11
    } dir_src_e;

    typedef struct packed {
        logic                 halt_mode;
        dir_src_e             dir_src;
        logic [1:0]           fixed_ones;
        logic [CLK_SEL_W-1:0] clk_sel;
    } mode_t;

    typedef struct packed {
        logic stb;
        logic down;
    } step_t;

    function automatic logic step_down(mode_t m, logic hw_pin);
        logic d;
        case (m.dir_src)
            DIR_SW_UP: d = 1'b0;
            DIR_SW_DN: d = 1'b1;
            default:   d = hw_pin;
        endcase
        return d;
    endfunction

    function automatic mode_t mode_from_bits(logic [MODE_W-1:0] b);
        mode_t m;
        m = mode_t'(b);
        m.fixed_ones = 2'b11;
        return m;
    endfunction

endpackage

// File: rtl/tmr_ctrl_regs.sv
module tmr_ctrl_regs
    import tmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              mode_we,
    input  logic [MODE_W-1:0] mode_wd,
    input  logic              stby_we,
    input  logic              stby_wd,
    input  logic              ien_we,
    input  logic              ien_wd,
    output mode_t             mode_q,
    output logic              run_q,
    output logic              ien_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= mode_t'(MODE_RST);
            run_q  <= 1'b1;
            ien_q  <= 1'b0;
        end else begin
            if (mode_we) mode_q <= mode_from_bits(mode_wd);
            if (stby_we) run_q  <= stby_wd;
            if (ien_we)  ien_q  <= ien_wd;
        end
    end

endmodule

// File: rtl/tmr_step_sel.sv
module tmr_step_sel
    import tmr_pkg::*;
(
    input  logic              run,
    input  mode_t             mode,
    input  logic [N_TAPS-1:0] tap_stb,
    input  logic              ext_stb,
    input  logic              hw_down,
    output step_t             step
);

    logic [N_SRC-1:0] src;

    for (genvar i = 0; i < N_SRC; i++) begin : g_src
        if (i < N_TAPS) begin : g_tap
            assign src[i] = tap_stb[i];
        end else begin : g_ext
            assign src[i] = ext_stb;
        end
    end

    always_comb begin
        step.stb  = run && !mode.halt_mode && src[mode.clk_sel];
        step.down = step_down(mode, hw_down);
    end

endmodule

// File: rtl/tmr_counter.sv
module tmr_counter
    import tmr_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  step_t            step,
    output logic [CNT_W-1:0] count,
    output logic             wrap
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    always_comb begin
        wrap = step.stb && (step.down ? (count == '0) : (count == CNT_MAX));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
        end else if (step.stb) begin
            count <= step.down ? (count - CNT_ONE) : (count + CNT_ONE);
        end
    end

endmodule

// File: rtl/tmr_wrap_flag.sv
module tmr_wrap_flag (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic wrap,
    input  logic clr_req,
    output logic flag
);

    always_ff @(posedge clk) begin
        if (rst) begin
            flag <= 1'b0;
        end else if (wrap) begin
            flag <= 1'b1;
        end else if (clr_req && run) begin
            flag <= 1'b0;
        end
    end

endmodule

// File: rtl/updn_interval_timer.sv
module updn_interval_timer
    import tmr_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mode_we,
    input  logic [7:0]        mode_wd,
    output logic [7:0]        mode_o,
    input  logic              stby_we,
    input  logic              stby_wd,
    output logic              run_o,
    input  logic              ien_we,
    input  logic              ien_wd,
    output logic              ien_o,
    input  logic              flag_clr,
    output logic              flag_o,
    output logic              irq_o,
    input  logic [6:0]        tap_stb,
    input  logic              ext_stb,
    input  logic              hw_down,
    output logic [CNT_W-1:0]  count_o
);

    mode_t mode_q;
    logic  run_q;
    logic  ien_q;
    step_t step;
    logic  wrap;
    logic  flag_q;

    tmr_ctrl_regs i_regs (
        .clk     (clk),
        .rst     (rst),
        .mode_we (mode_we),
        .mode_wd (mode_wd),
        .stby_we (stby_we),
        .stby_wd (stby_wd),
        .ien_we  (ien_we),
        .ien_wd  (ien_wd),
        .mode_q  (mode_q),
        .run_q   (run_q),
        .ien_q   (ien_q)
    );

    tmr_step_sel i_sel (
        .run     (run_q),
        .mode    (mode_q),
        .tap_stb (tap_stb),
        .ext_stb (ext_stb),
        .hw_down (hw_down),
        .step    (step)
    );

    tmr_counter #(.CNT_W(CNT_W)) i_cnt (
        .clk   (clk),
        .rst   (rst),
        .step  (step),
        .count (count_o),
        .wrap  (wrap)
    );

    tmr_wrap_flag i_flag (
        .clk     (clk),
        .rst     (rst),
        .run     (run_q),
        .wrap    (wrap),
        .clr_req (flag_clr),
        .flag    (flag_q)
    );

    assign mode_o = mode_q;
    assign run_o  = run_q;
    assign ien_o  = ien_q;
    assign flag_o = flag_q;
    assign irq_o  = flag_q && ien_q;

endmodule

// File: rtl/tmr_checker.sv
module tmr_checker #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic [7:0]       mode_o,
    input logic             run_o,
    input logic             ien_o,
    input logic             flag_clr,
    input logic             flag_o,
    input logic             irq_o,
    input logic [CNT_W-1:0] count_o
);

    localparam logic [CNT_W-1:0] ALL1 = '1;
    localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

    p_halt_hold_r1: assert property (@(posedge clk) disable iff (rst)
        mode_o[7] |=> count_o == $past(count_o));

    p_single_step_r3: assert property (@(posedge clk) disable iff (rst)
        run_o |=> (count_o == $past(count_o)) ||
                  (count_o == $past(count_o) + ONE) ||
                  (count_o == $past(count_o) - ONE));

    p_over_flags_r5: assert property (@(posedge clk) disable iff (rst)
        ($past(count_o) == ALL1 && count_o == '0) |-> flag_o);

    p_under_flags_r5: assert property (@(posedge clk) disable iff (rst)
        ($past(count_o) == '0 && count_o == ALL1) |-> flag_o);

    p_flag_sticky_r6: assert property (@(posedge clk) disable iff (rst)
        (flag_o && !flag_clr) |=> flag_o);

    p_irq_masked_r7: assert property (@(posedge clk) disable iff (rst)
        !ien_o |-> !irq_o);

    p_irq_raised_r7: assert property (@(posedge clk) disable iff (rst)
        (flag_o && ien_o) |-> irq_o);

    p_standby_count_r8: assert property (@(posedge clk) disable iff (rst)
        !run_o |=> count_o == $past(count_o));

    p_standby_flag_r8: assert property (@(posedge clk) disable iff (rst)
        (!run_o && flag_o) |=> flag_o);

endmodule

bind updn_interval_timer tmr_checker #(.CNT_W(CNT_W)) i_chk (
    .clk      (clk),
    .rst      (rst),
    .mode_o   (mode_o),
    .run_o    (run_o),
    .ien_o    (ien_o),
    .flag_clr (flag_clr),
    .flag_o   (flag_o),
    .irq_o    (irq_o),
    .count_o  (count_o)
);

// File: tb/test_updn_interval_timer.sv
module test_updn_interval_timer;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       mode_we = 1'b0;
    logic [7:0] mode_wd = '0;
    logic       stby_we = 1'b0;
    logic       stby_wd = 1'b0;
    logic       ien_we = 1'b0;
    logic       ien_wd = 1'b0;
    logic       flag_clr = 1'b0;
    logic [6:0] tap_stb = '0;
    logic       ext_stb = 1'b0;
    logic       hw_down = 1'b0;
    logic [7:0] mode_o;
    logic       run_o;
    logic       ien_o;
    logic       flag_o;
    logic       irq_o;
    logic [7:0] count_o;

    always #(CLK_PERIOD/2) clk = ~clk;

    updn_interval_timer i_updn_interval_timer (
        .clk      (clk),
        .rst      (rst),
        .mode_we  (mode_we),
        .mode_wd  (mode_wd),
        .mode_o   (mode_o),
        .stby_we  (stby_we),
        .stby_wd  (stby_wd),
        .run_o    (run_o),
        .ien_we   (ien_we),
        .ien_wd   (ien_wd),
        .ien_o    (ien_o),
        .flag_clr (flag_clr),
        .flag_o   (flag_o),
        .irq_o    (irq_o),
        .tap_stb  (tap_stb),
        .ext_stb  (ext_stb),
        .hw_down  (hw_down),
        .count_o  (count_o)
    );

    int n_vec = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    logic [7:0] m_mode = 8'h18;
    logic       m_run  = 1'b1;
    logic       m_ien  = 1'b0;
    logic [7:0] m_cnt  = 8'h00;
    logic       m_flag = 1'b0;

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    // Inputs were set at a falling edge; one rising edge passes, then the model
    // advances and every output is compared at the next falling edge.
    task automatic cyc(string req);
        logic [7:0] src;
        logic       stb;
        logic       dn;
        logic       wrp;
        @(negedge clk);
        src = {ext_stb, tap_stb};
        stb = m_run && !m_mode[7] && src[m_mode[2:0]];
        dn  = m_mode[6] ? hw_down : m_mode[5];
        wrp = 1'b0;
        if (stb) begin
            wrp   = dn ? (m_cnt == 8'h00) : (m_cnt == 8'hFF);
            m_cnt = dn ? m_cnt - 8'd1 : m_cnt + 8'd1;
        end
        if (wrp) m_flag = 1'b1;
        else if (flag_clr && m_run) m_flag = 1'b0;
        if (mode_we) m_mode = {mode_wd[7:5], 2'b11, mode_wd[2:0]};
        if (stby_we) m_run = stby_wd;
        if (ien_we)  m_ien = ien_wd;
        check(req, count_o, m_cnt);
        check(req, {7'd0, flag_o}, {7'd0, m_flag});
        check(req, {7'd0, irq_o}, {7'd0, m_flag && m_ien});
        check(req, mode_o, m_mode);
        check(req, {6'd0, run_o, ien_o}, {6'd0, m_run, m_ien});
        mode_we  = 1'b0;
        stby_we  = 1'b0;
        ien_we   = 1'b0;
        flag_clr = 1'b0;
        tap_stb  = '0;
        ext_stb  = 1'b0;
    endtask

    task automatic set_mode(logic [7:0] v, string req);
        mode_we = 1'b1;
        mode_wd = v;
        cyc(req);
    endtask

    task automatic ext_pulses(int n, string req);
        for (int k = 0; k < n; k++) begin
            ext_stb = 1'b1;
            cyc(req);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_vec++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R2: reset state, no strobe
        cyc("R2 reset");
        // R2: reserved bits 4..3 read back as 1
        set_mode(8'h00, "R2 fixed ones");

        // R3: every source against every select value
        for (int sel = 0; sel < 8; sel++) begin
            set_mode(8'(sel), "R3 select");
            for (int s = 0; s < 8; s++) begin
                if (s < 7) tap_stb[s] = 1'b1;
                else       ext_stb = 1'b1;
                cyc("R3 source sweep");
            end
            tap_stb = 7'h7F;
            ext_stb = 1'b1;
            cyc("R3 all strobes one step");
        end

        // R4: every direction setting with both pin levels
        for (int d = 0; d < 4; d++) begin
            for (int h = 0; h < 2; h++) begin
                set_mode({1'b0, 2'(d), 2'b00, 3'd7}, "R4 direction");
                hw_down = h[0];
                ext_pulses(3, "R4 direction steps");
            end
        end
        hw_down = 1'b0;

        // R5/R6: up through several wraps, clearing each cycle (wrap beats clear)
        set_mode(8'h07, "R5 up");
        for (int k = 0; k < 520; k++) begin
            ext_stb  = 1'b1;
            flag_clr = 1'b1;
            cyc("R5 R6 up wrap with clear");
        end
        set_mode(8'h27, "R5 down");
        for (int k = 0; k < 520; k++) begin
            ext_stb  = 1'b1;
            flag_clr = 1'b1;
            cyc("R5 R6 down wrap with clear");
        end
        // R5: hardware direction down through zero
        set_mode(8'h47, "R5 hw mode");
        hw_down = 1'b1;
        ext_pulses(300, "R5 hw down wrap");
        hw_down = 1'b0;

        // R6: flag sticky without clear, then cleared
        ext_pulses(20, "R6 sticky");
        flag_clr = 1'b1;
        cyc("R6 clear");
        cyc("R6 stays clear");

        // R7: interrupt gating
        set_mode(8'h07, "R7 up");
        ext_pulses(256, "R7 wrap masked");
        ien_we = 1'b1; ien_wd = 1'b1;
        cyc("R7 enable");
        ien_we = 1'b1; ien_wd = 1'b0;
        cyc("R7 disable");
        ien_we = 1'b1; ien_wd = 1'b1;
        cyc("R7 re-enable");
        flag_clr = 1'b1;
        cyc("R7 clear drops irq");

        // R8: standby holds count and flag, ignores strobes and clear
        ext_pulses(256, "R8 set flag");
        stby_we = 1'b1; stby_wd = 1'b0;
        cyc("R8 enter standby");
        for (int k = 0; k < 8; k++) begin
            ext_stb  = 1'b1;
            tap_stb  = 7'h7F;
            flag_clr = 1'b1;
            cyc("R8 strobes and clear ignored");
        end
        set_mode(8'h20, "R8 mode write in standby");
        ien_we = 1'b1; ien_wd = 1'b0;
        cyc("R8 enable write in standby");
        stby_we = 1'b1; stby_wd = 1'b1;
        cyc("R8 leave standby");
        tap_stb[0] = 1'b1;
        cyc("R8 resumed down step");

        // R1: halt bit freezes the count
        set_mode(8'h87, "R1 halt");
        ext_pulses(10, "R1 halted");
        set_mode(8'h07, "R1 interval");
        ext_pulses(5, "R1 counting again");

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule